// File: doc/BRIEF.md
# Banked GPIO Controller with Wake Logic

This block manages a bank of 32 general-purpose pins behind a small memory-mapped register bus. Each pin has an output latch, a direction bit, a two-bit function select, a stored pull-disable bit and a stored sleep-control bit. The latch, direction and function bits drive the pad-side outputs. Data and direction can be written whole, or changed one bit at a time through write-one set and clear aliases. This lets software change one pin without a read-modify-write.

Raw pad inputs pass through a two-flop synchroniser. An edge detector follows it and feeds two independent event paths:
- The interrupt path has its own rising and falling masks and a sticky status register. The `irq` output is the OR of its status bits.
- The wake path has a second, separate pair of masks and its own sticky status register. The `wake` output is the OR of its status bits.

The register bus has no back-pressure. A write presented with `bus_wr_en` high is taken at that clock edge, and a write can be issued in every cycle. Read data is combinational from `bus_addr`, so it is valid in the same cycle and no strobe is needed.

Top module: `gpio_bank_top`

## Requirements
- R1: At reset every register, `pad_out`, `pad_oe`, `irq` and `wake` are zero.
- R2: Plain read/write registers read back what was last written. They are: data latch 0x00, pull-disable 0x0C, direction 0x10, sleep-control 0x1C, function-select A 0x20, function-select B 0x24, rising irq mask 0x40, falling irq mask 0x44, rising wake mask 0x50 and falling wake mask 0x54. Pull-disable appears on `pull_dis` and sleep-control appears on `sleep_cfg`.
- R3: A write to 0x04 sets the data-latch bits where the write data is 1. A write to 0x08 clears them. Zero bits leave the latch unchanged. Both aliases read as 0.
- R4: A write to 0x14 sets direction bits and a write to 0x18 clears them, with the same write-one rules. `pad_oe` equals the direction register (1 = drive), and `pad_out` equals the data latch.
- R5: Reading 0x00 returns the latch bit for pins whose direction is 1, and the synchronised pad input for pins whose direction is 0.
- R6: A pad change made before clock edge E first appears in the 0x00 read after edge E+1, and is not yet visible after edge E.
- R7: `pin_func[2i+1:2i]` is {select-B bit i, select-A bit i}. The codes are 0 = GPIO, 1 = function A, 2 = function B and 3 = function C.
- R8: Interrupt status (read at 0x48) bit i sets on a rising edge when rising-mask bit i is 1, and on a falling edge when falling-mask bit i is 1. Unmasked edges set nothing.
- R9: A status bit stays set until 1 is written to that bit at 0x4C, and writing 0 there has no effect. An enabled edge arriving in the same cycle as the clear leaves the bit set.
- R10: Wake status (read at 0x58) is set only through the wake masks, independently of the irq masks. It is cleared by writing 1s to 0x58.
- R11: `irq` is high exactly when any interrupt status bit is set. `wake` is high exactly when any wake status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, taken at the clock edge |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 32 | Raw pad inputs (asynchronous) |
| pad_out | output | 32 | Output latch to pads |
| pad_oe | output | 32 | Output enable per pin |
| pull_dis | output | 32 | Stored pull-disable bits |
| sleep_cfg | output | 32 | Stored sleep-control bits |
| pin_func | output | 64 | Two-bit function code per pin |
| irq | output | 1 | Any interrupt status bit set |
| wake | output | 1 | Any wake status bit set |

## Verification
The hardest case to reach is an enabled edge that lands in the same cycle as a clear write to an already-set status bit, because the edge is delayed by three flops before it reaches the status register. The stimulus first sets the bit with one edge. It then changes the pad in the opposite direction, counts two clock edges, and places the clear write so that it is taken at the third edge, the one where the detected event arrives. A status read after that must still show the bit set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_AW = 8;

  localparam logic [BUS_AW-1:0] OFS_DATA    = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_DATA_S  = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_DATA_C  = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_PULL    = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_DIR     = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_DIR_S   = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_DIR_C   = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_SLEEP   = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_FSEL_A  = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_FSEL_B  = 8'h24;
  localparam logic [BUS_AW-1:0] OFS_IRQ_RM  = 8'h40;
  localparam logic [BUS_AW-1:0] OFS_IRQ_FM  = 8'h44;
  localparam logic [BUS_AW-1:0] OFS_IRQ_ST  = 8'h48;
  localparam logic [BUS_AW-1:0] OFS_IRQ_CLR = 8'h4C;
  localparam logic [BUS_AW-1:0] OFS_WK_RM   = 8'h50;
  localparam logic [BUS_AW-1:0] OFS_WK_FM   = 8'h54;
  localparam logic [BUS_AW-1:0] OFS_WK_ST   = 8'h58;

  typedef enum logic [1:0] {
    FN_GPIO = 2'd0,
    FN_A    = 2'd1,
    FN_B    = 2'd2,
    FN_C    = 2'd3
  } pin_fn_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_stat.sv
module gpio_edge_stat #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] event_hit,
  output logic [WIDTH-1:0] status,
  output logic             any_set
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign event_hit = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);

  // a fresh event overrides a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | event_hit;
  end

  assign status  = stat_q;
  assign any_set = |stat_q;
endmodule

// File: rtl/gpio_func_map.sv
module gpio_func_map
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]   sel_a,
  input  logic [WIDTH-1:0]   sel_b,
  output logic [2*WIDTH-1:0] code
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pin_fn_e fn;
    always_comb begin
      unique case ({sel_b[i], sel_a[i]})
        2'b01:   fn = FN_A;
        2'b10:   fn = FN_B;
        2'b11:   fn = FN_C;
        default: fn = FN_GPIO;
      endcase
    end
    assign code[2*i +: 2] = fn;
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  sync_in,
  input  logic [WIDTH-1:0]  irq_stat,
  input  logic [WIDTH-1:0]  wake_stat,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  dout,
  output logic [WIDTH-1:0]  dir,
  output logic [WIDTH-1:0]  pull,
  output logic [WIDTH-1:0]  sleep,
  output logic [WIDTH-1:0]  fsel_a,
  output logic [WIDTH-1:0]  fsel_b,
  output logic [WIDTH-1:0]  irq_rm,
  output logic [WIDTH-1:0]  irq_fm,
  output logic [WIDTH-1:0]  wk_rm,
  output logic [WIDTH-1:0]  wk_fm,
  output logic [WIDTH-1:0]  irq_clr,
  output logic [WIDTH-1:0]  wake_clr
);
  function automatic logic hit(input logic [BUS_AW-1:0] a, input logic [BUS_AW-1:0] ofs);
    return a == ofs;
  endfunction

  logic wr_data, wr_data_s, wr_data_c, wr_dir, wr_dir_s, wr_dir_c;

  assign wr_data   = wr_en && hit(addr, OFS_DATA);
  assign wr_data_s = wr_en && hit(addr, OFS_DATA_S);
  assign wr_data_c = wr_en && hit(addr, OFS_DATA_C);
  assign wr_dir    = wr_en && hit(addr, OFS_DIR);
  assign wr_dir_s  = wr_en && hit(addr, OFS_DIR_S);
  assign wr_dir_c  = wr_en && hit(addr, OFS_DIR_C);

  always_ff @(posedge clk) begin
    if (!rst_n)         dout <= '0;
    else if (wr_data)   dout <= wdata;
    else if (wr_data_s) dout <= dout | wdata;
    else if (wr_data_c) dout <= dout & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        dir <= '0;
    else if (wr_dir)   dir <= wdata;
    else if (wr_dir_s) dir <= dir | wdata;
    else if (wr_dir_c) dir <= dir & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pull   <= '0;
      sleep  <= '0;
      fsel_a <= '0;
      fsel_b <= '0;
      irq_rm <= '0;
      irq_fm <= '0;
      wk_rm  <= '0;
      wk_fm  <= '0;
    end else if (wr_en) begin
      unique case (addr)
        OFS_PULL:   pull   <= wdata;
        OFS_SLEEP:  sleep  <= wdata;
        OFS_FSEL_A: fsel_a <= wdata;
        OFS_FSEL_B: fsel_b <= wdata;
        OFS_IRQ_RM: irq_rm <= wdata;
        OFS_IRQ_FM: irq_fm <= wdata;
        OFS_WK_RM:  wk_rm  <= wdata;
        OFS_WK_FM:  wk_fm  <= wdata;
        default: ;
      endcase
    end
  end

  assign irq_clr  = (wr_en && hit(addr, OFS_IRQ_CLR)) ? wdata : '0;
  assign wake_clr = (wr_en && hit(addr, OFS_WK_ST))   ? wdata : '0;

  always_comb begin
    unique case (addr)
      OFS_DATA:   rdata = (dir & dout) | (~dir & sync_in);
      OFS_PULL:   rdata = pull;
      OFS_DIR:    rdata = dir;
      OFS_SLEEP:  rdata = sleep;
      OFS_FSEL_A: rdata = fsel_a;
      OFS_FSEL_B: rdata = fsel_b;
      OFS_IRQ_RM: rdata = irq_rm;
      OFS_IRQ_FM: rdata = irq_fm;
      OFS_IRQ_ST: rdata = irq_stat;
      OFS_WK_RM:  rdata = wk_rm;
      OFS_WK_FM:  rdata = wk_fm;
      OFS_WK_ST:  rdata = wake_stat;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [N_PINS-1:0]   bus_wdata,
  output logic [N_PINS-1:0]   bus_rdata,
  input  logic [N_PINS-1:0]   pad_in,
  output logic [N_PINS-1:0]   pad_out,
  output logic [N_PINS-1:0]   pad_oe,
  output logic [N_PINS-1:0]   pull_dis,
  output logic [N_PINS-1:0]   sleep_cfg,
  output logic [2*N_PINS-1:0] pin_func,
  output logic                irq,
  output logic                wake
);
  logic [N_PINS-1:0] sync_in;
  logic [N_PINS-1:0] dout, dir, fsel_a, fsel_b;
  logic [N_PINS-1:0] irq_rm, irq_fm, wk_rm, wk_fm;
  logic [N_PINS-1:0] irq_clr, wake_clr;
  logic [N_PINS-1:0] irq_ev, wake_ev, irq_stat, wake_stat;

  gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (sync_in)
  );

  gpio_regfile #(.WIDTH(N_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr_en),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .sync_in   (sync_in),
    .irq_stat  (irq_stat),
    .wake_stat (wake_stat),
    .rdata     (bus_rdata),
    .dout      (dout),
    .dir       (dir),
    .pull      (pull_dis),
    .sleep     (sleep_cfg),
    .fsel_a    (fsel_a),
    .fsel_b    (fsel_b),
    .irq_rm    (irq_rm),
    .irq_fm    (irq_fm),
    .wk_rm     (wk_rm),
    .wk_fm     (wk_fm),
    .irq_clr   (irq_clr),
    .wake_clr  (wake_clr)
  );

  gpio_edge_stat #(.WIDTH(N_PINS)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (sync_in),
    .rise_en   (irq_rm),
    .fall_en   (irq_fm),
    .clr       (irq_clr),
    .event_hit (irq_ev),
    .status    (irq_stat),
    .any_set   (irq)
  );

  gpio_edge_stat #(.WIDTH(N_PINS)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (sync_in),
    .rise_en   (wk_rm),
    .fall_en   (wk_fm),
    .clr       (wake_clr),
    .event_hit (wake_ev),
    .status    (wake_stat),
    .any_set   (wake)
  );

  gpio_func_map #(.WIDTH(N_PINS)) u_fmap (
    .sel_a (fsel_a),
    .sel_b (fsel_b),
    .code  (pin_func)
  );

  assign pad_out = dout;
  assign pad_oe  = dir;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [N-1:0]      bus_wdata,
  input logic [N-1:0]      pad_oe,
  input logic              irq,
  input logic              wake,
  input logic [N-1:0]      irq_stat,
  input logic [N-1:0]      irq_ev,
  input logic [N-1:0]      irq_clr,
  input logic [N-1:0]      wake_stat,
  input logic [N-1:0]      wake_ev,
  input logic [N-1:0]      wake_clr
);
  // R4
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFS_DIR_S) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFS_DIR_C) |=> ((pad_oe & $past(bus_wdata)) == '0));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_stat) & ~$past(irq_clr)) & ~irq_stat) == '0));

  // R9
  irq_edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_ev) & ~irq_stat) == '0));

  // R8
  irq_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_stat & ~$past(irq_stat) & ~$past(irq_ev)) == '0));

  // R10
  wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(wake_stat) & ~$past(wake_clr)) & ~wake_stat) == '0));

  // R10
  wake_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wake_stat & ~$past(wake_stat) & ~$past(wake_ev)) == '0));

  // R11
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|irq_ev));

  // R11
  wake_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake) |-> $past(|wake_ev));
endmodule

bind gpio_bank_top gpio_bank_chk #(.N(N_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .wake      (wake),
  .irq_stat  (irq_stat),
  .irq_ev    (irq_ev),
  .irq_clr   (irq_clr),
  .wake_stat (wake_stat),
  .wake_ev   (wake_ev),
  .wake_clr  (wake_clr)
);

// File: tb/tb_gpio_bank_top.sv
module tb_gpio_bank_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pull_dis, sleep_cfg;
  logic [63:0] pin_func;
  logic        irq, wake;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  gpio_bank_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_dis(pull_dis),
    .sleep_cfg(sleep_cfg), .pin_func(pin_func), .irq(irq), .wake(wake)
  );

  // {write address, write data, read address, expected read}
  localparam logic [79:0] VECS [0:14] = '{
    {8'h10, 32'hFFFF_FFFF, 8'h10, 32'hFFFF_FFFF},
    {8'h00, 32'hA5A5_0000, 8'h00, 32'hA5A5_0000},
    {8'h04, 32'h0000_000F, 8'h00, 32'hA5A5_000F},
    {8'h08, 32'hA000_0003, 8'h00, 32'h05A5_000C},
    {8'h18, 32'hFFFF_0000, 8'h10, 32'h0000_FFFF},
    {8'h14, 32'h00F0_0000, 8'h10, 32'h00F0_FFFF},
    {8'h20, 32'h0000_000A, 8'h20, 32'h0000_000A},
    {8'h24, 32'h0000_000C, 8'h24, 32'h0000_000C},
    {8'h0C, 32'h1234_5678, 8'h0C, 32'h1234_5678},
    {8'h1C, 32'h9ABC_DEF0, 8'h1C, 32'h9ABC_DEF0},
    {8'h40, 32'h0000_0001, 8'h40, 32'h0000_0001},
    {8'h44, 32'h0000_0003, 8'h44, 32'h0000_0003},
    {8'h50, 32'h0000_0010, 8'h50, 32'h0000_0010},
    {8'h54, 32'h0000_0020, 8'h54, 32'h0000_0020},
    {8'h04, 32'h0000_0000, 8'h04, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd(8'h00, r); check("R1 data", r, 0);
    rd(8'h10, r); check("R1 dir", r, 0);
    rd(8'h48, r); check("R1 irq status", r, 0);
    check("R1 outputs", {pad_out, pad_oe}, 0);
    check("R1 irq/wake", {62'd0, irq, wake}, 0);

    // table: R2 stored registers, R3 data set/clear, R4 direction set/clear
    for (int i = 0; i < 15; i++) begin
      wr(VECS[i][79:72], VECS[i][71:40]);
      rd(VECS[i][39:32], r);
      check($sformatf("vector %0d (R2 R3 R4)", i), r, VECS[i][31:0]);
    end

    check("R4 pad_out", pad_out, 32'h05A5_000C);
    check("R4 pad_oe", pad_oe, 32'h00F0_FFFF);
    check("R2 pull_dis", pull_dis, 32'h1234_5678);
    check("R2 sleep_cfg", sleep_cfg, 32'h9ABC_DEF0);
    check("R7 pin_func", pin_func[7:0], 8'hE4);

    // R5 read mux: inputs read the pad, outputs read the latch
    pad_in = 32'hFF00_0000;
    cyc(3);
    rd(8'h00, r); check("R5 mixed read", r, 32'hFFA0_000C);

    // R6 two-flop latency on pin 16 (an input)
    pad_in = 32'hFF01_0000;
    cyc(1);
    rd(8'h00, r); check("R6 after one edge", r, 32'hFFA0_000C);
    cyc(1);
    rd(8'h00, r); check("R6 after two edges", r, 32'hFFA1_000C);

    cyc(3);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h58, 32'hFFFF_FFFF);
    rd(8'h48, r); check("R9 clear all", r, 0);

    // R8 rising edge on pin 0
    pad_in[0] = 1'b1;
    cyc(4);
    rd(8'h48, r); check("R8 rise pin0", r, 32'h1);
    check("R11 irq high", {63'd0, irq}, 1);

    // R9 writing 0 to the clear register has no effect
    wr(8'h4C, 32'h0);
    rd(8'h48, r); check("R9 zero clear", r, 32'h1);

    // R9 edge arriving with the clear wins
    pad_in[0] = 1'b0;
    cyc(2);
    wr(8'h4C, 32'h1);
    rd(8'h48, r); check("R9 edge wins over clear", r, 32'h1);
    wr(8'h4C, 32'h1);
    rd(8'h48, r); check("R9 clear", r, 0);
    check("R11 irq low", {63'd0, irq}, 0);

    // R8 pin 1: only falling edge enabled
    pad_in[1] = 1'b1;
    cyc(4);
    rd(8'h48, r); check("R8 pin1 rise ignored", r, 0);
    pad_in[1] = 1'b0;
    cyc(4);
    rd(8'h48, r); check("R8 pin1 fall", r, 32'h2);
    wr(8'h4C, 32'h2);

    // R8 pin 2 unmasked
    pad_in[2] = 1'b1;
    cyc(4);
    pad_in[2] = 1'b0;
    cyc(4);
    rd(8'h48, r); check("R8 unmasked pin2", r, 0);

    // R10 wake path with separate masks
    pad_in[4] = 1'b1;
    cyc(4);
    rd(8'h58, r); check("R10 wake rise pin4", r, 32'h10);
    rd(8'h48, r); check("R10 irq untouched", r, 0);
    check("R11 wake high", {63'd0, wake}, 1);
    pad_in[5] = 1'b1;
    cyc(4);
    rd(8'h58, r); check("R10 pin5 rise ignored", r, 32'h10);
    pad_in[5] = 1'b0;
    cyc(4);
    rd(8'h58, r); check("R10 pin5 fall", r, 32'h30);
    wr(8'h58, 32'h30);
    rd(8'h58, r); check("R10 wake clear", r, 0);
    check("R11 wake low", {63'd0, wake}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule